// File: doc/BRIEF.md
# Predicated Doubleword Swap Execution Unit

This unit executes one vector permute operation. Each 128-bit element of a source vector is rebuilt with its two 64-bit halves exchanged, and only the elements marked active by a governing predicate are rebuilt. Elements that are not active either keep what the destination vector held before or are cleared to zero. A bit of the instruction word picks which of these two behaviours applies.

The unit receives a 32-bit instruction word with a valid strobe. The same strobe brings the source vector, the current destination vector, the predicate value and two feature-enable flags. The unit checks the word against the operation's fixed opcode bits and decodes the register indices so that surrounding logic can fetch operands and write back the result. It reports an illegal encoding when the opcode does not match, or when the chosen form has its feature disabled. The result, the decoded indices, a write enable and the illegal flag are registered and appear one clock after the strobe. The vector length is a build-time parameter, a multiple of 128 from 128 to 2048 bits. The predicate has one bit per byte of the vector.

Top module: `dswap_unit`

## Requirements
- R1: An instruction word whose bits 31..14 are not exactly 000001010010111010 raises `illegal_o` and does not write a result.
- R2: `zd_o` carries instruction bits 4..0, `zn_o` carries bits 9..5 and `pg_o` carries bits 12..10. These are reported for every accepted word, legal or not.
- R3: For an active element e of a legal instruction, result bits [128e+63:128e] equal source bits [128e+127:128e+64], and result bits [128e+127:128e+64] equal source bits [128e+63:128e].
- R4: When instruction bit 13 is 0 (keep form), every inactive element of the result equals the same element of the destination input.
- R5: When instruction bit 13 is 1 (clear form), every inactive element of the result is zero.
- R6: Element e is active exactly when predicate bit 16e is 1. The other fifteen predicate bits of that element have no effect on the result.
- R7: The keep form is legal only while `en_keep_i` is 1, and the clear form is legal only while `en_clear_i` is 1. A form whose enable is 0 raises `illegal_o`.
- R8: `out_valid_o` is 1 in the cycle after each cycle in which `in_valid_i` is 1, and 0 after every other cycle. Back-to-back strobes give back-to-back results.
- R9: When `illegal_o` is 1, `wr_en_o` is 0 and `result_o` is zero. When a legal result is presented, `wr_en_o` is 1.
- R10: After a clock with `rst` high, `out_valid_o`, `wr_en_o` and `illegal_o` are 0.
- R11: When no element is active, the source data has no influence: the result is the destination input (keep form) or all zeros (clear form).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Strobe: operands and instruction present this cycle |
| instr_i | input | 32 | Instruction word |
| src_i | input | VL | Source vector |
| dst_i | input | VL | Current destination vector contents |
| pred_i | input | VL/8 | Governing predicate, one bit per byte |
| en_keep_i | input | 1 | Feature enable for the keep (merging) form |
| en_clear_i | input | 1 | Feature enable for the clear (zeroing) form |
| out_valid_o | output | 1 | Result cycle marker |
| illegal_o | output | 1 | Illegal encoding reported for the accepted word |
| wr_en_o | output | 1 | Destination write enable |
| zd_o | output | 5 | Decoded destination register index |
| zn_o | output | 5 | Decoded source register index |
| pg_o | output | 3 | Decoded predicate register index |
| result_o | output | VL | Result vector |

## Verification
The bench builds the unit with a 512-bit vector, which gives four 128-bit elements and a 64-bit predicate. This size allows mixed active and inactive patterns in one word, with both an inactive element between active ones and the other way round. It also lets noise be placed in the fifteen predicate bits that must be ignored, in several elements at once. The default 512-bit build also shows that every element is placed and reversed within its own window.

// File: rtl/dswap_pkg.sv
package dswap_pkg;

    // Element geometry
    localparam int ELEM_W        = 128;
    localparam int HALF_W        = ELEM_W / 2;
    localparam int PRED_PER_ELEM = ELEM_W / 8;

    // Instruction word geometry
    localparam int INSTR_W   = 32;
    localparam int OPC_LSB   = 14;
    localparam int OPC_W     = INSTR_W - OPC_LSB;
    localparam int MODE_BIT  = 13;
    localparam int PG_LSB    = 10;
    localparam int PG_W      = 3;
    localparam int ZN_LSB    = 5;
    localparam int REG_W     = 5;
    localparam int ZD_LSB    = 0;

    // Fixed opcode bits 31..14
    localparam logic [OPC_W-1:0] OPC_FIXED = 18'b000001010010111010;

    typedef enum logic {
        INACT_KEEP  = 1'b0,
        INACT_CLEAR = 1'b1
    } inact_mode_e;

    typedef struct packed {
        logic              opc_hit;
        logic              feat_on;
        inact_mode_e       mode;
        logic [PG_W-1:0]   pg;
        logic [REG_W-1:0]  zn;
        logic [REG_W-1:0]  zd;
    } dec_s;

    typedef struct packed {
        logic             illegal;
        logic             wr_en;
        logic [PG_W-1:0]  pg;
        logic [REG_W-1:0] zn;
        logic [REG_W-1:0] zd;
    } out_ctl_s;

    function automatic logic [ELEM_W-1:0] swap_halves(input logic [ELEM_W-1:0] e);
        return {e[HALF_W-1:0], e[ELEM_W-1:HALF_W]};
    endfunction

endpackage

// File: rtl/dswap_decode.sv
module dswap_decode
    import dswap_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               en_keep,
    input  logic               en_clear,
    output dec_s               dec,
    output logic               legal
);
    logic       hit;
    inact_mode_e mode;
    logic       feat;

    always_comb begin
        hit  = (instr[INSTR_W-1:OPC_LSB] == OPC_FIXED);
        mode = inact_mode_e'(instr[MODE_BIT]);
        unique case (mode)
            INACT_KEEP:  feat = en_keep;
            INACT_CLEAR: feat = en_clear;
            default:     feat = 1'b0;
        endcase
    end

    always_comb begin
        dec.opc_hit = hit;
        dec.feat_on = feat;
        dec.mode    = mode;
        dec.pg      = instr[PG_LSB +: PG_W];
        dec.zn      = instr[ZN_LSB +: REG_W];
        dec.zd      = instr[ZD_LSB +: REG_W];
        legal       = hit & feat;
    end
endmodule

// File: rtl/dswap_lane.sv
module dswap_lane
    import dswap_pkg::*;
(
    input  logic [ELEM_W-1:0] src_elem,
    input  logic [ELEM_W-1:0] dst_elem,
    input  logic              active,
    input  inact_mode_e       mode,
    output logic [ELEM_W-1:0] res_elem
);
    always_comb begin
        if (active) begin
            res_elem = swap_halves(src_elem);
        end else if (mode == INACT_CLEAR) begin
            res_elem = '0;
        end else begin
            res_elem = dst_elem;
        end
    end
endmodule

// File: rtl/dswap_datapath.sv
module dswap_datapath
    import dswap_pkg::*;
#(
    parameter int VL = 512
) (
    input  logic [VL-1:0]   src,
    input  logic [VL-1:0]   dst,
    input  logic [VL/8-1:0] pred,
    input  inact_mode_e     mode,
    output logic [VL-1:0]   res
);
    localparam int NELEM = VL / ELEM_W;

    logic [NELEM-1:0] act;
    logic             any_act;
    logic [VL-1:0]    operand;
    logic             pred_unused;

    // One governing predicate bit per element: the lowest byte bit
    for (genvar e = 0; e < NELEM; e++) begin : g_act
        assign act[e] = pred[e*PRED_PER_ELEM];
    end

    assign pred_unused = ^pred;
    assign any_act     = |act;
    assign operand     = any_act ? src : '0;

    for (genvar e = 0; e < NELEM; e++) begin : g_lane
        dswap_lane u_lane (
            .src_elem (operand[e*ELEM_W +: ELEM_W]),
            .dst_elem (dst[e*ELEM_W +: ELEM_W]),
            .active   (act[e]),
            .mode     (mode),
            .res_elem (res[e*ELEM_W +: ELEM_W])
        );
    end
endmodule

// File: rtl/dswap_unit.sv
module dswap_unit
    import dswap_pkg::*;
#(
    parameter int VL = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid_i,
    input  logic [31:0]       instr_i,
    input  logic [VL-1:0]     src_i,
    input  logic [VL-1:0]     dst_i,
    input  logic [VL/8-1:0]   pred_i,
    input  logic              en_keep_i,
    input  logic              en_clear_i,
    output logic              out_valid_o,
    output logic              illegal_o,
    output logic              wr_en_o,
    output logic [4:0]        zd_o,
    output logic [4:0]        zn_o,
    output logic [2:0]        pg_o,
    output logic [VL-1:0]     result_o
);
    dec_s          dec;
    logic          legal;
    logic [VL-1:0] dp_res;
    out_ctl_s      ctl_q;
    logic          vld_q;
    logic [VL-1:0] res_q;

    dswap_decode u_decode (
        .instr    (instr_i),
        .en_keep  (en_keep_i),
        .en_clear (en_clear_i),
        .dec      (dec),
        .legal    (legal)
    );

    dswap_datapath #(.VL(VL)) u_dp (
        .src  (src_i),
        .dst  (dst_i),
        .pred (pred_i),
        .mode (dec.mode),
        .res  (dp_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ctl_q <= '0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid_i;
            if (in_valid_i) begin
                ctl_q.illegal <= ~legal;
                ctl_q.wr_en   <= legal;
                ctl_q.pg      <= dec.pg;
                ctl_q.zn      <= dec.zn;
                ctl_q.zd      <= dec.zd;
                res_q         <= legal ? dp_res : '0;
            end else begin
                ctl_q.illegal <= 1'b0;
                ctl_q.wr_en   <= 1'b0;
            end
        end
    end

    assign out_valid_o = vld_q;
    assign illegal_o   = ctl_q.illegal;
    assign wr_en_o     = ctl_q.wr_en;
    assign zd_o        = ctl_q.zd;
    assign zn_o        = ctl_q.zn;
    assign pg_o        = ctl_q.pg;
    assign result_o    = res_q;
endmodule

// File: rtl/dswap_unit_chk.sv
module dswap_unit_chk
    import dswap_pkg::*;
#(
    parameter int VL = 512
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid_i,
    input logic [31:0]     instr_i,
    input logic [VL/8-1:0] pred_i,
    input logic            en_clear_i,
    input logic            out_valid_o,
    input logic            illegal_o,
    input logic            wr_en_o,
    input logic [4:0]      zd_o,
    input logic [4:0]      zn_o,
    input logic [2:0]      pg_o,
    input logic [VL-1:0]   result_o
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> out_valid_o); // R8

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i |=> !out_valid_o); // R8

    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!wr_en_o && result_o == '0)); // R9

    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && instr_i[31:14] != OPC_FIXED) |=> illegal_o); // R1

    AST_FIELDS: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> (zd_o == $past(instr_i[4:0]) && zn_o == $past(instr_i[9:5])
                        && pg_o == $past(instr_i[12:10]))); // R2

    AST_CLEAR_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && instr_i[31:14] == OPC_FIXED && instr_i[13] && en_clear_i && !pred_i[0])
        |=> result_o[127:0] == '0); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid_o && !wr_en_o && !illegal_o)); // R10
endmodule

bind dswap_unit dswap_unit_chk #(.VL(VL)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid_i),
    .instr_i     (instr_i),
    .pred_i      (pred_i),
    .en_clear_i  (en_clear_i),
    .out_valid_o (out_valid_o),
    .illegal_o   (illegal_o),
    .wr_en_o     (wr_en_o),
    .zd_o        (zd_o),
    .zn_o        (zn_o),
    .pg_o        (pg_o),
    .result_o    (result_o)
);

// File: tb/dswap_unit_bench.sv
`timescale 1ns/1ps
module dswap_unit_bench;
    localparam int VL = 512;
    localparam int PW = VL / 8;
    localparam int NE = VL / 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid_i = 1'b0;
    logic [31:0]   instr_i = '0;
    logic [VL-1:0] src_i = '0;
    logic [VL-1:0] dst_i = '0;
    logic [PW-1:0] pred_i = '0;
    logic          en_keep_i = 1'b1;
    logic          en_clear_i = 1'b1;
    logic          out_valid_o, illegal_o, wr_en_o;
    logic [4:0]    zd_o, zn_o;
    logic [2:0]    pg_o;
    logic [VL-1:0] result_o;

    always #2 clk = ~clk;

    dswap_unit #(.VL(VL)) u_dswap_unit (.*);

    typedef struct {
        logic          illegal;
        logic [4:0]    zd, zn;
        logic [2:0]    pg;
        logic [VL-1:0] res;
        string         tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad   = 0;

    function automatic logic [31:0] mk(input logic z, input logic [2:0] pg,
                                       input logic [4:0] zn, input logic [4:0] zd);
        return {18'b000001010010111010, z, pg, zn, zd};
    endfunction

    function automatic logic [VL-1:0] pat(input int seed);
        logic [VL-1:0] v;
        for (int i = 0; i < VL/32; i++)
            v[i*32 +: 32] = (seed * 32'h9E3779B9) ^ (i * 32'h01010101 + 32'h5A00 + seed);
        return v;
    endfunction

    task automatic send(input logic [31:0] ins, input logic [VL-1:0] s, input logic [VL-1:0] d,
                        input logic [PW-1:0] p, input logic ek, input logic ec, input string tag);
        exp_t x;
        logic ill;
        @(negedge clk);
        instr_i = ins; src_i = s; dst_i = d; pred_i = p;
        en_keep_i = ek; en_clear_i = ec; in_valid_i = 1'b1;
        ill = (ins[31:14] != 18'b000001010010111010) || (ins[13] ? !ec : !ek);
        x.illegal = ill;
        x.zd = ins[4:0]; x.zn = ins[9:5]; x.pg = ins[12:10];
        x.tag = tag;
        for (int e = 0; e < NE; e++) begin
            if (ill)
                x.res[e*128 +: 128] = '0;
            else if (p[e*16])
                x.res[e*128 +: 128] = {s[e*128 +: 64], s[e*128+64 +: 64]};
            else if (ins[13])
                x.res[e*128 +: 128] = '0;
            else
                x.res[e*128 +: 128] = d[e*128 +: 128];
        end
        q.push_back(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid_i = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid_o) begin
                if (q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R8 unexpected out_valid act=1 exp=0");
                end else begin
                    exp_t x;
                    x = q.pop_front();
                    total++;
                    if (illegal_o !== x.illegal || wr_en_o !== !x.illegal) begin
                        bad++;
                        $display("FAIL %s R9 illegal/wr_en act=%b/%b exp=%b/%b",
                                 x.tag, illegal_o, wr_en_o, x.illegal, !x.illegal);
                    end
                    total++;
                    if (zd_o !== x.zd || zn_o !== x.zn || pg_o !== x.pg) begin
                        bad++;
                        $display("FAIL %s R2 fields act=%h/%h/%h exp=%h/%h/%h",
                                 x.tag, zd_o, zn_o, pg_o, x.zd, x.zn, x.pg);
                    end
                    total++;
                    if (result_o !== x.res) begin
                        bad++;
                        $display("FAIL %s result act=%h exp=%h", x.tag, result_o, x.res);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [PW-1:0] p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        total++;
        if (out_valid_o !== 1'b0 || wr_en_o !== 1'b0 || illegal_o !== 1'b0) begin
            bad++;
            $display("FAIL R10 reset act=%b%b%b exp=000", out_valid_o, wr_en_o, illegal_o);
        end

        // R3 all active, keep form
        p = '0;
        for (int e = 0; e < NE; e++) p[e*16] = 1'b1;
        send(mk(1'b0, 3'd5, 5'd17, 5'd3), pat(1), pat(2), p, 1, 1, "R3 all-active");
        // R4/R6 mixed, noise in ignored bits
        p = 64'hFFFE_0001_7FFE_0001;      // elements 0,2 active; 1,3 noisy but inactive
        send(mk(1'b0, 3'd7, 5'd31, 5'd0), pat(3), pat(4), p, 1, 0, "R4 R6 keep-mixed");
        // R5 clear form mixed, back-to-back
        p = 64'h0001_FFFE_0001_0000;      // elements 1 and 3 active
        send(mk(1'b1, 3'd2, 5'd9, 5'd22), pat(5), pat(6), p, 0, 1, "R5 R6 clear-mixed");
        // R11 none active, keep and clear
        send(mk(1'b0, 3'd1, 5'd4, 5'd8), pat(7), pat(8), 64'hFFFE_FFFE_FFFE_FFFE, 1, 1, "R11 R4 none-keep");
        send(mk(1'b1, 3'd0, 5'd6, 5'd10), pat(9), pat(10), '0, 1, 1, "R11 R5 none-clear");
        idle(2);
        // R8: quiet after idle
        total++;
        if (out_valid_o !== 1'b0) begin
            bad++;
            $display("FAIL R8 idle out_valid act=%b exp=0", out_valid_o);
        end
        // R1 bad opcode variants
        send(mk(1'b0, 3'd3, 5'd1, 5'd2) ^ 32'h0001_0000, pat(11), pat(12), '1, 1, 1, "R1 opcode-bit16");
        send(mk(1'b0, 3'd3, 5'd1, 5'd2) | 32'h0040_0000, pat(13), pat(14), '1, 1, 1, "R1 opcode-size");
        send(mk(1'b0, 3'd3, 5'd1, 5'd2) ^ 32'h0000_4000, pat(15), pat(16), '1, 1, 1, "R1 opcode-bit14");
        // R7 feature gating
        send(mk(1'b0, 3'd4, 5'd12, 5'd13), pat(17), pat(18), '1, 0, 1, "R7 keep-disabled");
        send(mk(1'b1, 3'd4, 5'd12, 5'd13), pat(19), pat(20), '1, 1, 0, "R7 clear-disabled");
        send(mk(1'b1, 3'd6, 5'd14, 5'd15), pat(21), pat(22), 64'h0000_0001_0000_0001, 0, 1, "R7 R5 clear-only-enabled");
        send(mk(1'b0, 3'd6, 5'd14, 5'd15), pat(23), pat(24), 64'h0001_0000_0001_0000, 1, 0, "R7 R4 keep-only-enabled");
        idle(3);
        // R8: every expected result was seen
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R8 pending results act=%0d exp=0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule